// File: doc/BRIEF.md
# LPC Low-Power Sequencer

This block steps the host side of an LPC bus into and out of its low-power state. A sleep request first drives the power-down indication low. One cycle later it shuts the gate on the peripheral DMA/master request inputs and parks the bus: the frame strobe is forced low and the address/data lines float. A down-counter then holds off the bus reset until a programmed number of clock cycles has passed. With the default of 1000 cycles this gives 30 µs at 33 MHz.

A core reset takes a different path. It drops power-down and bus reset on the same edge and overrides any sequence in progress. A wake request, seen only while the reset is held, releases the bus reset first and then the power-down indication. The request gate reopens one cycle after that. A separate clock-stop input gates the LPC clock enable, because stopping the bus clock also stops the LPC clock. A busy output marks every state other than normal running.

Top module: `lpc_sleep_seq`

## Requirements
- R1: While and after reset, with no request pending, `pd_n`, `bus_rst_n`, `req_gate_en`, `lpc_clk_en` are 1, and `busy`, `frame_lo`, `data_hiz` are 0.
- R2: In the running state, `sleep_req` sampled high on an edge drives `pd_n` low and `busy` high after that edge, while `bus_rst_n` stays high.
- R3: `req_gate_en` falls one cycle after `pd_n` falls. `frame_lo` and `data_hiz` go high one cycle after `pd_n` falls on a sleep entry.
- R4: On a sleep entry, `bus_rst_n` falls exactly `GAP_CYCLES` clock cycles after `pd_n` falls, and never sooner. `GAP_CYCLES` must be at least 2.
- R5: `core_rst_req` sampled high on an edge in any state drives both `pd_n` and `bus_rst_n` low after that edge, with no delay between them.
- R6: `wake_req` has no effect before the bus reset is held. A wake pulse during the power-down wait does not shorten or cancel the wait, and `bus_rst_n` still falls at `GAP_CYCLES` and stays low.
- R7: With the reset held, `wake_req` high and `core_rst_req` low on an edge raise `bus_rst_n` after that edge while `pd_n` stays low. On the next edge `pd_n` rises, and `busy`, `frame_lo` and `data_hiz` fall.
- R8: `req_gate_en` rises one cycle after `pd_n` rises on exit.
- R9: While `core_rst_req` is high, the reset is held even if `wake_req` is high.
- R10: `lpc_clk_en` equals the inverse of `clk_stop_req` one cycle later.
- R11: `busy` is low only in the running state. Whenever it is low, `pd_n` and `bus_rst_n` are high and the bus is not parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter low power |
| core_rst_req | input | 1 | Core reset request, highest priority |
| wake_req | input | 1 | Request to leave low power |
| clk_stop_req | input | 1 | Clock-run request to stop the bus clock |
| pd_n | output | 1 | Power-down indication, active low |
| bus_rst_n | output | 1 | LPC bus reset, active low |
| frame_lo | output | 1 | Force frame strobe low |
| data_hiz | output | 1 | Float the address/data lines |
| req_gate_en | output | 1 | Enable for peripheral request input buffers |
| lpc_clk_en | output | 1 | LPC clock enable |
| busy | output | 1 | Sequencer away from the running state |

## Verification
Directed scenarios drive a plain sleep entry and a core reset from running. Comparing them shows the timed gap against simultaneous assertion. A core reset issued mid-wait shows that priority cuts the counter short. A wake pulse during the wait shows it is ignored, and a wake held against an active core reset shows the reset stays held. The exit pattern checks the release order cycle by cycle, including the one-cycle delay before the request gate reopens.

// File: rtl/lpc_sleep_seq.sv
module lpc_sleep_seq #(
  parameter int GAP_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic core_rst_req,
  input  logic wake_req,
  input  logic clk_stop_req,
  output logic pd_n,
  output logic bus_rst_n,
  output logic frame_lo,
  output logic data_hiz,
  output logic req_gate_en,
  output logic lpc_clk_en,
  output logic busy
);

  localparam int CW = $clog2(GAP_CYCLES + 1) + 1;

  typedef enum logic [2:0] {ST_RUN, ST_PD, ST_WAIT, ST_RST, ST_EXIT} st_t;

  st_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_RUN;
      cnt <= '0;
    end else if (core_rst_req) begin
      st  <= ST_RST;
      cnt <= '0;
    end else begin
      case (st)
        ST_RUN:  if (sleep_req) begin
                   st  <= ST_PD;
                   cnt <= CW'(GAP_CYCLES - 1);
                 end
        ST_PD:   begin
                   st  <= ST_WAIT;
                   cnt <= cnt - 1'b1;
                 end
        ST_WAIT: if (cnt == '0) st <= ST_RST;
                 else cnt <= cnt - 1'b1;
        ST_RST:  if (wake_req) st <= ST_EXIT;
        ST_EXIT: st <= ST_RUN;
        default: st <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_gate_en <= 1'b1;
      lpc_clk_en  <= 1'b1;
    end else begin
      req_gate_en <= (st == ST_RUN);
      lpc_clk_en  <= !clk_stop_req;
    end
  end

  assign pd_n      = (st == ST_RUN);
  assign bus_rst_n = (st != ST_RST);
  assign frame_lo  = (st == ST_WAIT) || (st == ST_RST) || (st == ST_EXIT);
  assign data_hiz  = frame_lo;
  assign busy      = (st != ST_RUN);

  // cycles the power-down indication has been low, saturating
  logic [CW-1:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (pd_n) low_cnt <= '0;
    else if (low_cnt != {CW{1'b1}}) low_cnt <= low_cnt + 1'b1;
  end

  assert_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_rst_n) && !$past(core_rst_req)) |-> (low_cnt >= CW'(GAP_CYCLES)));

  assert_core_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_req |=> (!pd_n && !bus_rst_n));

  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !req_gate_en);

  assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_n) |-> (bus_rst_n && $past(bus_rst_n)));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pd_n && bus_rst_n && !frame_lo && !data_hiz));

  assert_clk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_stop_req) |=> !lpc_clk_en);

endmodule

// File: tb/sim_lpc_sleep_seq.sv
module sim_lpc_sleep_seq;
  localparam int G = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, core_rst_req = 1'b0, wake_req = 1'b0, clk_stop_req = 1'b0;
  logic pd_n, bus_rst_n, frame_lo, data_hiz, req_gate_en, lpc_clk_en, busy;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  lpc_sleep_seq #(.GAP_CYCLES(G)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .core_rst_req(core_rst_req),
    .wake_req(wake_req), .clk_stop_req(clk_stop_req), .pd_n(pd_n), .bus_rst_n(bus_rst_n),
    .frame_lo(frame_lo), .data_hiz(data_hiz), .req_gate_en(req_gate_en),
    .lpc_clk_en(lpc_clk_en), .busy(busy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enter_sleep(output int gap);
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R2 pd_n", pd_n, 0);
    chk("R2 busy", busy, 1);
    chk("R2 bus_rst_n", bus_rst_n, 1);
    chk("R3 gate still open", req_gate_en, 1);
    gap = 0;
    while (bus_rst_n && gap < 5 * G) begin
      step();
      gap++;
      if (gap == 1) begin
        chk("R3 gate closed", req_gate_en, 0);
        chk("R3 frame_lo", frame_lo, 1);
        chk("R3 data_hiz", data_hiz, 1);
      end
    end
  endtask

  task automatic do_exit();
    wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    chk("R7 bus_rst_n released", bus_rst_n, 1);
    chk("R7 pd_n held", pd_n, 0);
    step();
    chk("R7 pd_n released", pd_n, 1);
    chk("R7 busy", busy, 0);
    chk("R7 frame_lo", frame_lo, 0);
    chk("R7 data_hiz", data_hiz, 0);
    chk("R8 gate still closed", req_gate_en, 0);
    step();
    chk("R8 gate reopened", req_gate_en, 1);
  endtask

  task automatic t_reset();
    chk("R1 pd_n", pd_n, 1);
    chk("R1 bus_rst_n", bus_rst_n, 1);
    chk("R1 gate", req_gate_en, 1);
    chk("R1 clk_en", lpc_clk_en, 1);
    chk("R1 busy", busy, 0);
    chk("R1 frame_lo", frame_lo, 0);
    chk("R1 data_hiz", data_hiz, 0);
    chk("R11 idle", busy, 0);
  endtask

  task automatic t_sleep();
    int gap;
    enter_sleep(gap);
    chk("R4 gap", gap, G);
    do_exit();
  endtask

  task automatic t_core_run();
    core_rst_req = 1'b1;
    step();
    core_rst_req = 1'b0;
    chk("R5 pd_n", pd_n, 0);
    chk("R5 bus_rst_n", bus_rst_n, 0);
    do_exit();
  endtask

  task automatic t_core_wait();
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    step(3);
    chk("R5 before core", bus_rst_n, 1);
    core_rst_req = 1'b1;
    step();
    core_rst_req = 1'b0;
    chk("R5 override bus_rst_n", bus_rst_n, 0);
    chk("R5 override pd_n", pd_n, 0);
    do_exit();
  endtask

  task automatic t_wake_ignored();
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    step(2);
    wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    chk("R6 still powered", bus_rst_n, 1);
    chk("R6 still busy", busy, 1);
    step(G - 4);
    chk("R6 before gap", bus_rst_n, 1);
    step();
    chk("R6 reset at gap", bus_rst_n, 0);
    step(3);
    chk("R6 reset held", bus_rst_n, 0);
    do_exit();
  endtask

  task automatic t_core_hold();
    core_rst_req = 1'b1;
    wake_req = 1'b1;
    step(3);
    chk("R9 held bus_rst_n", bus_rst_n, 0);
    chk("R9 held pd_n", pd_n, 0);
    core_rst_req = 1'b0;
    wake_req = 1'b0;
    step();
    chk("R9 still held", bus_rst_n, 0);
    do_exit();
  endtask

  task automatic t_clock();
    clk_stop_req = 1'b1;
    chk("R10 before", lpc_clk_en, 1);
    step();
    chk("R10 stopped", lpc_clk_en, 0);
    clk_stop_req = 1'b0;
    step();
    chk("R10 restarted", lpc_clk_en, 1);
  endtask

  initial begin
    fork
      begin
        step(2);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_sleep();
        t_core_run();
        t_core_wait();
        t_wake_ignored();
        t_core_hold();
        t_clock();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule